// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Line Transmitter

This block turns a stream of stereo sample pairs into the serial line signal of a consumer digital audio link. Every sample travels in a 32-bit sub-frame. Sub-frame 1 of a frame carries the left sample and sub-frame 2 carries the right sample. A block holds 192 such frames. Data bits go out as biphase-mark symbols. Each sub-frame opens with an 8-state sync pattern that breaks the biphase rules on purpose, so that a receiver can lock onto sub-frame and block boundaries.

The line advances one symbol state for each pulse of a clock enable that runs at twice the bit rate, which gives 128 pulses per frame. At the first pulse of each frame the block offers a handshake slot for a new sample pair. When no pair is waiting, it resends the previous samples and marks them as not valid. A 192-bit channel-status value is supplied as a static input and is captured once per block.

Top module: `bmc_audio_tx`

## Requirements
- R1: Asserting the active-low reset forces `tx_out` low at once. After release, transmission starts at frame 0 with the block-start sync pattern, and the stored samples are zero.
- R2: `tx_out` changes only in a clock cycle where `sym_ce` is high. One frame takes exactly 128 `sym_ce` pulses, 64 for each sub-frame.
- R3: Sub-frame bits 4 to 31 are biphase-mark coded. The first state of each bit is the inverse of the state sent just before it. The second state equals the first for a 0 and is the inverse of the first for a 1.
- R4: Sub-frame bits 0 to 3 form an 8-state sync pattern, sent first state first. Channel 1 of frame 0 uses 11101000. Channel 1 of every other frame uses 11100010. Channel 2 always uses 11100100. These values apply when the preceding line state is low; when it is high, every state of the pattern is inverted.
- R5: Bits 4 to 27 carry the sample with its LSB first (left sample in channel 1, right sample in channel 2). Bit 28 is the validity flag, bit 29 is the user bit and is always 0, and bit 30 is the channel-status bit.
- R6: Bit 31 makes the count of ones in bits 4 to 31 even.
- R7: `smp_ready` is high only in the cycle of the `sym_ce` pulse that begins a frame. If `smp_valid` is high in that cycle, the pair on `smp_left` and `smp_right` is captured and sent in that frame with validity bit 0. Later changes on the sample inputs have no effect on that frame.
- R8: If `smp_valid` is low at a frame start, the previously captured pair is sent again with validity bit 1.
- R9: The channel-status bit sent in both sub-frames of frame n is bit n of `cs_word`, as captured at the start of frame 0. A change of `cs_word` later in the block has no effect until the next block.
- R10: After frame 191 the frame count returns to 0, and the next channel 1 sub-frame uses the block-start sync pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_ce | input | 1 | Symbol-state enable, two pulses per bit |
| cs_word | input | 192 | Channel-status bits, bit n belongs to frame n |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | Frame-start slot for taking a sample pair |
| smp_left | input | 24 | Channel 1 sample |
| smp_right | input | 24 | Channel 2 sample |
| tx_out | output | 1 | Serial line output |

## Verification
The bench decodes the line back into bits and sync patterns, so a wrong sync choice at frame 0 or after the wrap from frame 191 shows up as a pattern mismatch, and a missing inversion at a bit edge shows up as a coding violation. It changes the sample inputs right after the handshake slot and changes the channel-status input in the middle of a block. A design that reads live inputs instead of captured ones therefore sends the wrong sample or status bit. Frames without an offered pair check both that the old samples are repeated and that the validity flag is set. Every frame is checked for even parity, and clock cycles without an enable pulse are checked for a line that does not move. A reset in the middle of a frame must bring the line low and restart transmission at the block-start pattern.

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx #(
  parameter int SAMPLE_W = 24,
  parameter int FRAMES   = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_ce,
  input  logic [FRAMES-1:0]   cs_word,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                tx_out
);
  localparam int SUB_BITS = SAMPLE_W + 8;
  localparam int BW       = $clog2(SUB_BITS);
  localparam int FW       = $clog2(FRAMES);
  localparam logic [7:0] SYNC_BLK = 8'b11101000;
  localparam logic [7:0] SYNC_CH1 = 8'b11100010;
  localparam logic [7:0] SYNC_CH2 = 8'b11100100;

  logic [FW-1:0]       frame_q;
  logic                sub_q;
  logic [BW-1:0]       bit_q;
  logic                half_q;
  logic                pol_q;
  logic                tx_q;
  logic                vflag_q;
  logic [SAMPLE_W-1:0] left_q, right_q;
  logic [FRAMES-1:0]   cs_q;

  logic                frame_start, take, in_sync, cs_bit, par, tx_d;
  logic [2:0]          k;
  logic [7:0]          sync_pat;
  logic [SAMPLE_W-1:0] samp;
  logic [SUB_BITS-1:0] sub_word;

  assign frame_start = !sub_q && bit_q == '0 && !half_q;
  assign smp_ready   = sym_ce && frame_start;
  assign take        = smp_ready && smp_valid;
  assign in_sync     = bit_q < BW'(4);
  assign k           = {bit_q[1:0], half_q};
  assign samp        = sub_q ? right_q : left_q;
  assign cs_bit      = cs_q[frame_q];
  assign par         = ^{cs_bit, vflag_q, samp};
  assign sub_word    = {par, cs_bit, 1'b0, vflag_q, samp, 4'b0000};
  assign sync_pat    = sub_q ? SYNC_CH2 : (frame_q == '0 ? SYNC_BLK : SYNC_CH1);
  assign tx_out      = tx_q;

  always_comb begin
    if (in_sync)
      tx_d = sync_pat[~k] ^ (k == 3'd0 ? tx_q : pol_q);
    else if (half_q)
      tx_d = tx_q ^ sub_word[bit_q];
    else
      tx_d = ~tx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      sub_q   <= 1'b0;
      bit_q   <= '0;
      half_q  <= 1'b0;
      pol_q   <= 1'b0;
      tx_q    <= 1'b0;
    end else if (sym_ce) begin
      tx_q   <= tx_d;
      half_q <= ~half_q;
      if (in_sync && k == 3'd0) pol_q <= tx_q;
      if (half_q) begin
        if (bit_q == BW'(SUB_BITS - 1)) begin
          bit_q <= '0;
          sub_q <= ~sub_q;
          if (sub_q) frame_q <= (frame_q == FW'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      vflag_q <= 1'b0;
      cs_q    <= '0;
    end else begin
      if (take) begin
        left_q  <= smp_left;
        right_q <= smp_right;
        vflag_q <= 1'b0;
      end else if (smp_ready) begin
        vflag_q <= 1'b1;
      end
      if (smp_ready && frame_q == '0) cs_q <= cs_word;
    end
  end
endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sym_ce,
  input logic smp_ready,
  input logic tx_out
);
  logic [6:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (sym_ce) cnt <= cnt + 1'b1;
  end

  a_r2_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_ce |=> $stable(tx_out));

  a_r7_ready_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> (sym_ce && cnt == 7'd0));

  a_r3_bit_edge_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ce && cnt[5:0] >= 6'd8 && !cnt[0]) |=> tx_out != $past(tx_out));

  a_r6_parity_restores_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ce && cnt[5:0] == 6'd0) |-> !tx_out);

  a_r4_sync_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ce && cnt[5:0] < 6'd3) |=> tx_out);
endmodule

bind bmc_audio_tx bmc_audio_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sym_ce   (sym_ce),
  .smp_ready(smp_ready),
  .tx_out   (tx_out)
);

// File: tb/bmc_audio_tx_bench.sv
module bmc_audio_tx_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sym_ce = 1'b0;
  logic [191:0] cs_word;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [23:0]  smp_left, smp_right;
  logic         tx_out;

  bmc_audio_tx u_bmc_audio_tx (
    .clk(clk), .rst_n(rst_n), .sym_ce(sym_ce), .cs_word(cs_word),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .tx_out(tx_out)
  );

  always #5 clk = ~clk;

  // {offer, left, right}
  localparam logic [48:0] VEC [8] = '{
    {1'b1, 24'h000001, 24'h800000},
    {1'b1, 24'hFFFFFF, 24'h000000},
    {1'b0, 24'h111111, 24'h222222},
    {1'b1, 24'h5A5A5A, 24'hA5A5A5},
    {1'b0, 24'h333333, 24'h444444},
    {1'b0, 24'h555555, 24'h666666},
    {1'b1, 24'h123456, 24'hFEDCBA},
    {1'b1, 24'h7FFFFF, 24'h000100}
  };
  localparam logic [7:0] P_B = 8'b11101000;
  localparam logic [7:0] P_M = 8'b11100010;
  localparam logic [7:0] P_W = 8'b11100100;

  int          n_chk = 0, n_bad = 0, tick_n = 0;
  bit          done = 0;
  logic        last_st;
  logic [23:0] exp_l, exp_r;
  logic        exp_v;
  logic        st  [128];
  logic        rdy [128];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(output logic s, output logic r);
    logic prev;
    tick_n++;
    if (tick_n % 3 == 0) begin
      prev = tx_out;
      sym_ce = 1'b0;
      @(posedge clk); #2;
      chk(tx_out === prev, "R2 line holds without enable", 32'(tx_out), 32'(prev));
    end
    sym_ce = 1'b1;
    #1 r = smp_ready;
    @(posedge clk); #2;
    s = tx_out;
    sym_ce = 1'b0;
  endtask

  task automatic run_frame(input int fr, input bit offer, input logic [23:0] l,
                           input logic [23:0] r, input logic [191:0] cs_exp);
    int          extra;
    int          viol;
    logic        p, prevs, s0, s1;
    logic [7:0]  got, pat;
    logic [31:0] w;
    smp_valid = offer;
    smp_left  = l;
    smp_right = r;
    if (offer) begin exp_l = l; exp_r = r; exp_v = 1'b0; end
    else exp_v = 1'b1;
    for (int i = 0; i < 128; i++) begin
      tick(st[i], rdy[i]);
      if (i == 0) begin smp_valid = 1'b0; smp_left = ~l; smp_right = ~r; end
    end
    chk(rdy[0] === 1'b1, "R7 ready at frame start", 32'(rdy[0]), 32'd1);
    extra = 0;
    for (int i = 1; i < 128; i++) if (rdy[i] !== 1'b0) extra++;
    chk(extra == 0, "R7 ready only at frame start", 32'(extra), 32'd0);
    for (int h = 0; h < 2; h++) begin
      p   = (h == 0) ? last_st : st[63];
      pat = (h == 1) ? P_W : (fr == 0 ? P_B : P_M);
      for (int k = 0; k < 8; k++) got[7-k] = st[64*h + k];
      // R10: frame 0 (also after wrap and after reset R1) must open with the block pattern
      chk(got === (pat ^ {8{p}}), (fr == 0 && h == 0) ? "R10 block-start sync" : "R4 sync pattern",
          32'(got), 32'(pat ^ {8{p}}));
      w = '0; viol = 0; prevs = st[64*h + 7];
      for (int j = 4; j < 32; j++) begin
        s0 = st[64*h + 2*j];
        s1 = st[64*h + 2*j + 1];
        if (s0 === prevs) viol++;
        w[j] = s0 ^ s1;
        prevs = s1;
      end
      chk(viol == 0, "R3 bit first state inverts", 32'(viol), 32'd0);
      chk(w[27:4] === (h == 1 ? exp_r : exp_l), offer ? "R7 captured sample (R5 layout)" : "R8 repeated sample",
          32'(w[27:4]), 32'(h == 1 ? exp_r : exp_l));
      chk(w[28] === exp_v, offer ? "R7 validity clear" : "R8 validity set", 32'(w[28]), 32'(exp_v));
      chk(w[29] === 1'b0, "R5 user bit zero", 32'(w[29]), 32'd0);
      chk(w[30] === cs_exp[fr], "R9 channel status bit", 32'(w[30]), 32'(cs_exp[fr]));
      chk((^w[31:4]) === 1'b0, "R6 even parity", 32'(^w[31:4]), 32'd0);
    end
    last_st = st[127];
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [191:0] cs1, cs2;
    logic         d0, d1;
    cs1 = {6{32'h8E3C51D7}};
    cs2 = ~cs1;
    cs_word = cs1;
    smp_left = '0;
    smp_right = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(tx_out === 1'b0, "R1 line low in reset", 32'(tx_out), 32'd0);
    chk(smp_ready === 1'b0, "R1 no ready in reset", 32'(smp_ready), 32'd0);
    rst_n = 1'b1;
    last_st = 1'b0; exp_l = '0; exp_r = '0; exp_v = 1'b0;
    @(posedge clk); #2;

    for (int i = 0; i < 8; i++)
      run_frame(i, VEC[i][48], VEC[i][47:24], VEC[i][23:0], cs1);

    for (int fr = 8; fr < 192; fr++) begin
      if (fr == 100) cs_word = cs2; // R9: mid-block change must not show
      run_frame(fr, (fr % 16) == 0, {8'(fr), ~8'(fr), 8'(fr)}, {~8'(fr), 8'(fr), 8'hC3}, cs1);
    end

    // R10 wrap into a second block, which now carries cs2
    run_frame(0, 1'b1, 24'hABCDEF, 24'h010203, cs2);
    run_frame(1, 1'b0, 24'h0, 24'h0, cs2);
    run_frame(2, 1'b1, 24'h800001, 24'h7FFFFE, cs2);

    for (int i = 0; i < 50; i++) tick(d0, d1);
    rst_n = 1'b0;
    #1;
    chk(tx_out === 1'b0, "R1 mid-frame reset drives line low", 32'(tx_out), 32'd0);
    @(posedge clk); @(posedge clk); #2;
    rst_n = 1'b1;
    last_st = 1'b0; exp_l = '0; exp_r = '0;
    @(posedge clk); #2;
    run_frame(0, 1'b0, 24'h0, 24'h0, cs2); // R1 restart at frame 0, zero samples
    run_frame(1, 1'b1, 24'h0F0F0F, 24'hF0F0F0, cs2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule